// File: doc/BRIEF.md
# Two-Phase Cursor Sequencer

This block is a very small programmable engine that steers a cursor around an 8x8 pixel grid. A program of eight 3-bit opcodes sits in a local program store. A 3-bit program counter walks through that store. Two 3-bit coordinate registers, column and row, name the lit pixel. One adder is shared by all three registers. Each instruction takes two clocks. In the first clock, the display phase, the opcode may move or clear the cursor. In the second clock, the sequencing phase, the same opcode decides the next program counter. One of those sequencing choices branches on a single user input bit, so a program can let a player nudge the cursor.

To load a program, hold the block in reset and write words through a simple write port. Then release reset. The cursor coordinates, the program counter and the phase bit come out as registered values. A registered 64-bit one-hot map of the lit pixel also comes out, with bit index row*8+column. The map is useful for driving a grid of indicators directly.

Top module: `cursor_machine`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is pc=0, col=0, row=0 and phase=0, and the map has only bit 0 set.
- R2: After reset, `phase_o` inverts on every clock edge, so every opcode gets one display clock (phase 0) followed by one sequencing clock (phase 1).
- R3: In phase 0, opcode 100 adds 1 to the column and opcode 110 subtracts 1 from it, modulo 8. The row stays as it is, and the program counter never changes in phase 0.
- R4: In phase 0, opcode 101 adds 1 to the row and opcode 111 subtracts 1 from it, modulo 8. The column stays as it is.
- R5: In phase 0, opcode 011 sets both the column and the row to 0. Opcodes 000, 001 and 010 leave both unchanged.
- R6: In phase 1, opcode 000 advances the pc by 1 when `user_in` is 0 and by 2 when it is 1, modulo 8. `user_in` is sampled on the phase-1 edge. Column and row never change in phase 1.
- R7: In phase 1, opcode 001 adds 4 to the pc, modulo 8.
- R8: In phase 1, opcode 010 sets the pc to 0.
- R9: In phase 1, opcode 011 and every opcode of the form 1xx advance the pc by 1, modulo 8.
- R10: A write with `prog_we` high while `rst` is high stores `prog_data` at `prog_addr`. Writes while `rst` is low are ignored, and the program that runs is unchanged.
- R11: `disp_map_o` is one-hot, with bit row*8+column set. It changes in the same cycle as `x_o` and `y_o`.
- R12: The steering program 101,000,001,100,010,010,110,010 (listed from address 0 upward) runs as R2–R9 predict for any sequence of user input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the program store may be written only while it is high |
| user_in | input | 1 | User bit that selects the branch of opcode 000 |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | W (3) | Program store write address |
| prog_data | input | 3 | Opcode to write |
| x_o | output | W (3) | Cursor column |
| y_o | output | W (3) | Cursor row |
| pc_o | output | W (3) | Program counter |
| phase_o | output | 1 | 0 = display phase, 1 = sequencing phase |
| disp_map_o | output | 2^(2W) (64) | One-hot pixel map, bit row*8+column |

## Verification
The bench builds the block with its default width of 3. That gives an eight-word program store, an 8x8 grid and a 3-bit counter. At that size, a program made entirely of one opcode drives each coordinate and the pc around their full modulo-8 cycle. Every opcode can therefore be checked in both phases against every wrap. Pseudo-random programs and user bit patterns then cover the opcode mixes. The steering program and write attempts made outside reset are also covered. After every clock, each output is compared with an arithmetic model kept in the bench.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_BRU  = 3'b000,
    OP_JMP4 = 3'b001,
    OP_ZPC  = 3'b010,
    OP_ZXY  = 3'b011,
    OP_XINC = 3'b100,
    OP_YINC = 3'b101,
    OP_XDEC = 3'b110,
    OP_YDEC = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    B_ZERO,
    B_ONE,
    B_TWO,
    B_FOUR,
    B_MONE
  } bconst_e;

  typedef struct packed {
    bconst_e b;
    logic    src_disp;
    logic    sel_y;
    logic    clr_disp;
    logic    clr_pc;
  } ctrl_t;

endpackage

// File: rtl/cursor_prog_mem.sv
module cursor_prog_mem #(
  parameter int W    = 3,
  parameter int OP_W = 3
) (
  input  logic            clk,
  input  logic            we,
  input  logic [W-1:0]    waddr,
  input  logic [OP_W-1:0] wdata,
  input  logic [W-1:0]    raddr,
  output logic [OP_W-1:0] rdata
);
  localparam int DEPTH = 1 << W;

  logic [OP_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    rdata <= store[raddr];
  end
endmodule

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic  phase,
  input  op_e   op,
  input  logic  user,
  output ctrl_t ctl
);
  always_comb begin
    ctl.b        = B_ZERO;
    ctl.src_disp = ~phase;
    ctl.sel_y    = 1'b0;
    ctl.clr_disp = 1'b0;
    ctl.clr_pc   = 1'b0;
    if (!phase) begin
      unique case (op)
        OP_ZXY:  ctl.clr_disp = 1'b1;
        OP_XINC: ctl.b = B_ONE;
        OP_YINC: begin ctl.b = B_ONE;  ctl.sel_y = 1'b1; end
        OP_XDEC: ctl.b = B_MONE;
        OP_YDEC: begin ctl.b = B_MONE; ctl.sel_y = 1'b1; end
        default: ctl.b = B_ZERO;
      endcase
    end else begin
      unique case (op)
        OP_BRU:  ctl.b = user ? B_TWO : B_ONE;
        OP_JMP4: ctl.b = B_FOUR;
        OP_ZPC:  ctl.clr_pc = 1'b1;
        default: ctl.b = B_ONE;
      endcase
    end
  end
endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrl_t        ctl,
  output logic         phase_q,
  output logic [W-1:0] pc_q,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] pc_nxt,
  output logic [W-1:0] x_nxt,
  output logic [W-1:0] y_nxt
);
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [W-1:0] sum;
  logic [W-1:0] pc_d, x_d, y_d;

  always_comb begin
    if (ctl.src_disp) begin
      opa = ctl.sel_y ? y_q : x_q;
    end else begin
      opa = pc_q;
    end
  end

  always_comb begin
    unique case (ctl.b)
      B_ONE:   opb = W'(1);
      B_TWO:   opb = W'(2);
      B_FOUR:  opb = W'(4);
      B_MONE:  opb = '1;
      default: opb = '0;
    endcase
  end

  assign sum = opa + opb;

  always_comb begin
    pc_d = pc_q;
    x_d  = x_q;
    y_d  = y_q;
    if (phase_q) begin
      pc_d = ctl.clr_pc ? '0 : sum;
    end else if (ctl.clr_disp) begin
      x_d = '0;
      y_d = '0;
    end else if (ctl.sel_y) begin
      y_d = sum;
    end else begin
      x_d = sum;
    end
  end

  assign pc_nxt = rst ? '0 : pc_d;
  assign x_nxt  = rst ? '0 : x_d;
  assign y_nxt  = rst ? '0 : y_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= ~phase_q;
    end
    pc_q <= pc_nxt;
    x_q  <= x_nxt;
    y_q  <= y_nxt;
  end
endmodule

// File: rtl/cursor_map.sv
module cursor_map #(
  parameter int W = 3
) (
  input  logic                  clk,
  input  logic [W-1:0]          x_nxt,
  input  logic [W-1:0]          y_nxt,
  output logic [(1<<(2*W))-1:0] map_q
);
  localparam int MAP_W = 1 << (2 * W);

  logic [2*W-1:0]   idx;
  logic [MAP_W-1:0] map_d;

  assign idx   = {y_nxt, x_nxt};
  assign map_d = MAP_W'(1) << idx;

  always_ff @(posedge clk) begin
    map_q <= map_d;
  end
endmodule

// File: rtl/cursor_machine.sv
module cursor_machine
  import cursor_pkg::*;
#(
  parameter int W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  user_in,
  input  logic                  prog_we,
  input  logic [W-1:0]          prog_addr,
  input  logic [2:0]            prog_data,
  output logic [W-1:0]          x_o,
  output logic [W-1:0]          y_o,
  output logic [W-1:0]          pc_o,
  output logic                  phase_o,
  output logic [(1<<(2*W))-1:0] disp_map_o
);
  logic [OP_W-1:0] cur_op;
  ctrl_t           ctl;
  logic [W-1:0]    pc_nxt, x_nxt, y_nxt;

  cursor_prog_mem #(.W(W), .OP_W(OP_W)) mem_i (
    .clk   (clk),
    .we    (prog_we & rst),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc_nxt),
    .rdata (cur_op)
  );

  cursor_ctrl ctrl_i (
    .phase (phase_o),
    .op    (op_e'(cur_op)),
    .user  (user_in),
    .ctl   (ctl)
  );

  cursor_datapath #(.W(W)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .phase_q (phase_o),
    .pc_q    (pc_o),
    .x_q     (x_o),
    .y_q     (y_o),
    .pc_nxt  (pc_nxt),
    .x_nxt   (x_nxt),
    .y_nxt   (y_nxt)
  );

  cursor_map #(.W(W)) map_i (
    .clk   (clk),
    .x_nxt (x_nxt),
    .y_nxt (y_nxt),
    .map_q (disp_map_o)
  );
endmodule

// File: rtl/cursor_machine_chk.sv
module cursor_machine_chk #(
  parameter int W = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  phase,
  input logic [W-1:0]          pc,
  input logic [W-1:0]          x,
  input logic [W-1:0]          y,
  input logic [(1<<(2*W))-1:0] map,
  input logic [2:0]            op
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (pc == '0 && x == '0 && y == '0 && !phase));

  p_phase_flip_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase != $past(phase)));

  p_pc_still_r3: assert property (@(posedge clk) disable iff (rst)
    !phase |=> $stable(pc));

  p_xy_still_r6: assert property (@(posedge clk) disable iff (rst)
    phase |=> ($stable(x) && $stable(y)));

  p_jump4_r7: assert property (@(posedge clk) disable iff (rst)
    (phase && op == 3'b001) |=> (pc == W'($past(pc) + W'(4))));

  p_pc_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (phase && op == 3'b010) |=> (pc == '0));

  p_step_one_r9: assert property (@(posedge clk) disable iff (rst)
    (phase && (op == 3'b011 || op[2])) |=> (pc == W'($past(pc) + W'(1))));

  p_clear_xy_r5: assert property (@(posedge clk) disable iff (rst)
    (!phase && op == 3'b011) |=> (x == '0 && y == '0));

  p_map_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(map) == 1 && map[{y, x}]));
endmodule

bind cursor_machine cursor_machine_chk #(.W(W)) chk_i (
  .clk   (clk),
  .rst   (rst),
  .phase (phase_o),
  .pc    (pc_o),
  .x     (x_o),
  .y     (y_o),
  .map   (disp_map_o),
  .op    (cur_op)
);

// File: tb/cursor_machine_tb_top.sv
module cursor_machine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 3;
  localparam int DEPTH      = 1 << W;
  localparam int MAP_W      = 1 << (2 * W);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             user_in = 1'b0;
  logic             prog_we = 1'b0;
  logic [W-1:0]     prog_addr = '0;
  logic [2:0]       prog_data = '0;
  logic [W-1:0]     x_o, y_o, pc_o;
  logic             phase_o;
  logic [MAP_W-1:0] disp_map_o;

  cursor_machine #(.W(W)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .user_in    (user_in),
    .prog_we    (prog_we),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data),
    .x_o        (x_o),
    .y_o        (y_o),
    .pc_o       (pc_o),
    .phase_o    (phase_o),
    .disp_map_o (disp_map_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          n_tests = 0;
  int          n_fail  = 0;
  logic [2:0]  prog [DEPTH];
  logic [W-1:0] m_pc, m_x, m_y;
  logic        m_ph;
  logic [15:0] lfsr = 16'hACE1;
  string       last_tag = "R1";
  string       tag_ovr  = "";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Model of R3-R9 as plain arithmetic modulo 8
  task automatic model_step(input logic u);
    logic [2:0] op;
    op = prog[m_pc];
    if (!m_ph) begin
      case (op)
        3'b100: begin m_x = m_x + 1; last_tag = "R3"; end
        3'b110: begin m_x = m_x - 1; last_tag = "R3"; end
        3'b101: begin m_y = m_y + 1; last_tag = "R4"; end
        3'b111: begin m_y = m_y - 1; last_tag = "R4"; end
        3'b011: begin m_x = 0; m_y = 0; last_tag = "R5"; end
        default: last_tag = "R5";
      endcase
    end else begin
      case (op)
        3'b000:  begin m_pc = m_pc + (u ? 2 : 1); last_tag = "R6"; end
        3'b001:  begin m_pc = m_pc + 4; last_tag = "R7"; end
        3'b010:  begin m_pc = 0; last_tag = "R8"; end
        default: begin m_pc = m_pc + 1; last_tag = "R9"; end
      endcase
    end
    m_ph = ~m_ph;
  endtask

  task automatic check_state();
    string t;
    logic [MAP_W-1:0] emap;
    t = (tag_ovr != "") ? tag_ovr : last_tag;
    emap = MAP_W'(1) << (m_y * 8 + m_x);
    chk(pc_o == m_pc, t, "pc", pc_o, m_pc);
    chk(x_o == m_x, t, "col", x_o, m_x);
    chk(y_o == m_y, t, "row", y_o, m_y);
    chk(phase_o == m_ph, "R2", "phase", phase_o, m_ph);
    chk(disp_map_o == emap, "R11", "map", disp_map_o, emap);
  endtask

  // R10: program written only while reset is high
  task automatic load_program();
    rst = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = W'(a); prog_data = prog[a];
    end
    @(negedge clk);
    prog_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_pc = 0; m_x = 0; m_y = 0; m_ph = 1'b0;
    chk(pc_o == 0 && x_o == 0 && y_o == 0 && phase_o == 1'b0, "R1",
        "reset state", {pc_o, x_o, y_o, phase_o}, 0);
    chk(disp_map_o == MAP_W'(1), "R1", "reset map", disp_map_o, 1);
  endtask

  task automatic run_cycles(input int n, input bit noisy_writes);
    for (int i = 0; i < n; i++) begin
      lfsr = lfsr_next(lfsr);
      user_in = lfsr[0];
      if (noisy_writes) begin
        prog_we = 1'b1;
        prog_addr = W'(i);
        prog_data = ~prog[i % DEPTH];
      end
      model_step(user_in);
      @(negedge clk);
      check_state();
    end
    prog_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Uniform programs: every opcode in both phases, full wrap of col/row/pc
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < DEPTH; a++) prog[a] = 3'(op);
      load_program();
      run_cycles(40, 1'b0);
    end
    // Pseudo-random opcode mixes with random user bits
    for (int k = 0; k < 8; k++) begin
      for (int a = 0; a < DEPTH; a++) begin
        lfsr = lfsr_next(lfsr);
        prog[a] = lfsr[2:0];
      end
      load_program();
      run_cycles(60, 1'b0);
    end
    // R10: writes while running must not alter the program
    prog[0] = 3'b100; prog[1] = 3'b000; prog[2] = 3'b111; prog[3] = 3'b001;
    prog[4] = 3'b101; prog[5] = 3'b011; prog[6] = 3'b110; prog[7] = 3'b010;
    load_program();
    tag_ovr = "R10";
    run_cycles(64, 1'b1);
    tag_ovr = "";
    // R12: steering program
    prog[0] = 3'b101; prog[1] = 3'b000; prog[2] = 3'b001; prog[3] = 3'b100;
    prog[4] = 3'b010; prog[5] = 3'b010; prog[6] = 3'b110; prog[7] = 3'b010;
    load_program();
    tag_ovr = "R12";
    run_cycles(200, 1'b0);
    tag_ovr = "";
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule